// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block merges several reset requests into a single stretched processor reset. Three requests are accepted: a supply-undervoltage flag produced by an external comparator, an active-low manual reset pin, and a watchdog trip. Reset is held for as long as any request is active. Once the last request clears, reset stays asserted for a recovery interval. That interval is a parameter counted in clock cycles. A short value suits simulation, and a value equal to about 200 ms of clock time suits silicon.

The manual pin arrives asynchronously, so it passes through a two-flop synchronizer before it is used. It is ignored while a separate power-fail flag is low. Any request that arrives while the recovery count is running restarts that count from zero. The block leaves its own power-on reset with the processor reset asserted, and a full recovery count must run before reset is released.

Reset is driven at both polarities. A parameter selects the polarity of a third output, which is the one the processor consumes.

Top module: `supv_reset_gen`

## Requirements
- R1: While `rst_n` is low, `sys_rst_o` is 1. After `rst_n` rises with no request active, `sys_rst_o` falls only after exactly `TREC_CYCLES` rising edges.
- R2: `supply_low_i` high at a rising edge makes `sys_rst_o` 1 after that edge. Reset is released after the `TREC_CYCLES`-th consecutive edge at which no request is active.
- R3: Every assertion lasts at least `TREC_CYCLES` cycles. A one-cycle watchdog pulse from idle gives a pulse of exactly `TREC_CYCLES` cycles.
- R4: A request seen while the recovery count is running clears the count, and the full interval restarts once the request ends.
- R5: When `man_rst_n_i` is low, `sys_rst_o` is 1 after the third rising edge, because of two synchronizer stages plus the hold register. Reset stays asserted while the pin is low.
- R6: While `pwr_fail_n_i` is 0, a low on `man_rst_n_i` does not assert reset.
- R7: `sys_rst_n_o` is always the inverse of `sys_rst_o`. `proc_rst_o` equals `sys_rst_o` when `PROC_ACTIVE_HIGH` is 1, and equals `sys_rst_n_o` when it is 0.
- R8: `wdog_trip_i` high at a rising edge makes `sys_rst_o` 1 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Block power-on reset, active low, asynchronous |
| supply_low_i | input | 1 | Supply below threshold flag |
| man_rst_n_i | input | 1 | Manual reset pin, active low, asynchronous |
| wdog_trip_i | input | 1 | Watchdog trip request |
| pwr_fail_n_i | input | 1 | Power-fail flag; low gates the manual pin off |
| sys_rst_o | output | 1 | Stretched reset, active high |
| sys_rst_n_o | output | 1 | Stretched reset, active low |
| proc_rst_o | output | 1 | Processor reset at the polarity chosen by `PROC_ACTIVE_HIGH` |

## Verification
The assertions check the following on every cycle:
- A supply-low or watchdog request asserts reset on the next edge.
- A request zeroes the recovery count.
- The count advances by exactly one while it runs.
- Release happens only at the terminal count.
- A gated manual pin cannot move an idle block.

Only the bench scenarios can show the end-to-end outcomes:
- The exact pulse width after a single-cycle trip.
- The three-edge latency of the synchronized manual pin.
- A full restart when a second request lands in the middle of a count.
- The behaviour when all three requests overlap at random.

// File: rtl/supv_pkg.sv
package supv_pkg;
   function automatic int unsigned cnt_bits(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction
endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
   parameter int unsigned STAGES    = 2,
   parameter logic        RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("supv_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/supv_req_merge.sv
module supv_req_merge (
   input  logic supply_low_i,
   input  logic man_low_sync_i,
   input  logic pwr_fail_n_i,
   input  logic wdog_trip_i,
   output logic req_o
);
   logic man_gated;

   always_comb begin
      man_gated = man_low_sync_i & pwr_fail_n_i;
      req_o     = supply_low_i | man_gated | wdog_trip_i;
   end
endmodule

// File: rtl/supv_recovery_timer.sv
module supv_recovery_timer
   import supv_pkg::*;
#(
   parameter int unsigned TREC_CYCLES = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   input  logic supply_low_i,
   input  logic wdog_trip_i,
   input  logic pwr_fail_n_i,
   output logic hold_o
);
   localparam int unsigned CW = cnt_bits(TREC_CYCLES);
   localparam logic [CW-1:0] LAST = CW'(TREC_CYCLES - 1);

   if (TREC_CYCLES < 1) begin : g_bad_trec
      $error("supv_recovery_timer: TREC_CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt_q;
   logic          hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= 1'b1;
         cnt_q  <= '0;
      end else if (req_i) begin
         hold_q <= 1'b1;
         cnt_q  <= '0;
      end else if (hold_q) begin
         if (cnt_q == LAST) hold_q <= 1'b0;
         else               cnt_q  <= cnt_q + 1'b1;
      end
   end

   assign hold_o = hold_q;

   // R2 / R8: a supply or watchdog request forces reset on the next edge
   assert_src_asserts_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (supply_low_i || wdog_trip_i) |=> hold_q);

   // R4: any request zeroes the recovery count
   assert_req_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      req_i |=> (cnt_q == '0));

   // R2: count advances by one per quiet cycle while holding
   assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_q && !req_i && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));

   // R3: release happens only at the terminal count
   assert_min_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hold_q) |-> ($past(cnt_q) == LAST));

   // R6: gated manual pin cannot assert an idle block
   assert_man_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_q && !pwr_fail_n_i && !supply_low_i && !wdog_trip_i) |=> !hold_q);
endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen #(
   parameter int unsigned TREC_CYCLES      = 20,
   parameter int unsigned SYNC_STAGES      = 2,
   parameter bit          PROC_ACTIVE_HIGH = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_low_i,
   input  logic man_rst_n_i,
   input  logic wdog_trip_i,
   input  logic pwr_fail_n_i,
   output logic sys_rst_o,
   output logic sys_rst_n_o,
   output logic proc_rst_o
);
   logic man_n_sync;
   logic req;
   logic hold;

   supv_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_man_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (man_rst_n_i),
      .q_o   (man_n_sync)
   );

   supv_req_merge u_merge (
      .supply_low_i   (supply_low_i),
      .man_low_sync_i (~man_n_sync),
      .pwr_fail_n_i   (pwr_fail_n_i),
      .wdog_trip_i    (wdog_trip_i),
      .req_o          (req)
   );

   supv_recovery_timer #(.TREC_CYCLES(TREC_CYCLES)) u_timer (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_i        (req),
      .supply_low_i (supply_low_i),
      .wdog_trip_i  (wdog_trip_i),
      .pwr_fail_n_i (pwr_fail_n_i),
      .hold_o       (hold)
   );

   assign sys_rst_o   = hold;
   assign sys_rst_n_o = ~hold;

   if (PROC_ACTIVE_HIGH) begin : g_proc_high
      assign proc_rst_o = hold;
   end else begin : g_proc_low
      assign proc_rst_o = ~hold;
   end

   // R5: a synchronized, ungated manual low keeps reset asserted
   assert_man_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!man_n_sync && pwr_fail_n_i) |=> sys_rst_o);

   // R7: complementary outputs never agree
   assert_outputs_inverse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_o != sys_rst_n_o);
endmodule

// File: tb/supv_reset_gen_tb.sv
module supv_reset_gen_tb_top;
   localparam int unsigned TREC = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sup = 1'b0, man_n = 1'b1, wd = 1'b0, pf_n = 1'b1;
   logic sys_rst, sys_rst_n, proc_rst;

   int n_checks = 0;
   int n_fail = 0;
   string phase = "R1";

   // Reference state built from the requirements
   logic m_hold = 1'b1, m_s1 = 1'b1, m_s2 = 1'b1;
   int   m_cnt = 0;

   always #5 clk = ~clk;

   supv_reset_gen #(.TREC_CYCLES(TREC), .SYNC_STAGES(2), .PROC_ACTIVE_HIGH(1'b0)) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .supply_low_i (sup),
      .man_rst_n_i  (man_n),
      .wdog_trip_i  (wd),
      .pwr_fail_n_i (pf_n),
      .sys_rst_o    (sys_rst),
      .sys_rst_n_o  (sys_rst_n),
      .proc_rst_o   (proc_rst)
   );

   function automatic logic model_req(logic s, logic ms2, logic p, logic w);
      return s | (~ms2 & p) | w;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_hold = 1'b1; m_cnt = 0; m_s1 = 1'b1; m_s2 = 1'b1;
      end else begin
         if (model_req(sup, m_s2, pf_n, wd)) begin
            m_hold = 1'b1; m_cnt = 0;
         end else if (m_hold) begin
            if (m_cnt == TREC - 1) m_hold = 1'b0;
            else                   m_cnt++;
         end
         m_s2 = m_s1;
         m_s1 = man_n;
      end
   end

   task automatic check(input logic act, input logic exp, input string tag);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      check(sys_rst, m_hold, phase);
      check(sys_rst_n, ~m_hold, "R7 inverse");
      check(proc_rst, ~m_hold, "R7 proc polarity");
   end

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #(200000 * 10);
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      int width;
      void'($urandom(32'h5EED_0042));
      // R1: asserted in reset, released after full count
      phase = "R1";
      cyc(4);
      check(sys_rst, 1'b1, "R1 during reset");
      rst_n = 1'b1;
      cyc(TREC - 1);
      check(sys_rst, 1'b1, "R1 before terminal count");
      cyc(1);
      check(sys_rst, 1'b0, "R1 released after TREC");
      cyc(3);

      // R2: supply dip held then stretched
      phase = "R2";
      sup = 1'b1; cyc(4); sup = 1'b0;
      cyc(TREC - 1);
      check(sys_rst, 1'b1, "R2 before release");
      cyc(1);
      check(sys_rst, 1'b0, "R2 release");
      cyc(3);

      // R3 / R8: single-cycle watchdog trip gives exactly TREC cycles
      phase = "R8";
      wd = 1'b1; cyc(1); wd = 1'b0;
      check(sys_rst, 1'b1, "R8 trip asserts next edge");
      width = 1;
      for (int i = 0; i < TREC + 5; i++) begin
         cyc(1);
         if (sys_rst) width++;
      end
      check(width == TREC, 1'b1, "R3 pulse width");
      if (width != TREC) $display("FAIL R3 width: actual %0d expected %0d", width, TREC);

      // R4: mid-count request restarts count
      phase = "R4";
      sup = 1'b1; cyc(1); sup = 1'b0;
      cyc(TREC / 2);
      sup = 1'b1; cyc(1); sup = 1'b0;
      cyc(TREC - 1);
      check(sys_rst, 1'b1, "R4 restarted count still holding");
      cyc(1);
      check(sys_rst, 1'b0, "R4 release after full restart");
      cyc(3);

      // R5: manual reset through synchronizer
      phase = "R5";
      man_n = 1'b0;
      cyc(2);
      check(sys_rst, 1'b0, "R5 not yet through synchronizer");
      cyc(1);
      check(sys_rst, 1'b1, "R5 asserted on third edge");
      cyc(5); man_n = 1'b1;
      cyc(2 * TREC);
      check(sys_rst, 1'b0, "R5 released");

      // R6: manual ignored under power-fail
      phase = "R6";
      pf_n = 1'b0; man_n = 1'b0;
      for (int i = 0; i < 10; i++) begin
         cyc(1);
         check(sys_rst, 1'b0, "R6 manual gated");
      end
      man_n = 1'b1; cyc(3); pf_n = 1'b1;
      cyc(3);

      // Random mix of all requests
      phase = "R4 random";
      for (int i = 0; i < 3000; i++) begin
         sup   = ($urandom % 40) == 0;
         wd    = ($urandom % 50) == 0;
         if (($urandom % 30) == 0) man_n = ~man_n;
         if (($urandom % 25) == 0) pf_n  = ~pf_n;
         cyc(1);
      end
      sup = 1'b0; wd = 1'b0; man_n = 1'b1; pf_n = 1'b1;
      cyc(2 * TREC + 4);
      check(sys_rst, 1'b0, "R2 quiet after random");

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule